// File: doc/BRIEF.md
# Event Timer Register Front End

This block is the register-facing part of a multi-timer event timer. A single 64-bit port carries reads and writes of four or eight bytes. The block decodes its own global registers: an identity word that is built from parameters, a configuration word, a per-timer interrupt status word and a 32-bit main counter. It keeps the counter itself, stepping it on a tick enable. Accesses that land in a timer's window are not decoded here. They are passed on to the timer units as an index, a slot, data and a byte mask, and those units return read data.

A 4-byte access reaches either half of a 64-bit register. Bit 2 of the offset selects the half, and the write is merged under a mask so that the other half keeps its value. Status bits are set by strobes from the timer units. Software clears them by writing ones, and the block sends a matching release strobe for each cleared bit. A write to the counter, or a rising global enable, raises a rearm strobe for the timers.

Top module: `evt_regif`

## Requirements
- R1: Only size_i values 4 and 8 are legal. An access of any other size leaves all state unchanged, forwards nothing, and reads as zero.
- R2: An 8-byte access needs offset bits 2:0 at zero, and a 4-byte access needs offset bits 1:0 at zero. A misaligned access is ignored on write and reads as zero.
- R3: For a 4-byte access, offset bit 2 selects the upper half. Write data moves to bits 63:32 with the mask set there only, and the other half is kept. A 4-byte read returns the selected half in bits 31:0, with bits 63:32 at zero.
- R4: The identity register at offset 0x000 is read-only. It reads as follows: bits 7:0 = 1; bits 12:8 = NT-1; bit 13 (counter size) = 0; bits 15:14 = 0; bits 31:16 = VENDOR_ID; bits 63:32 = the tick period in femtoseconds, 10^15 / 2^TICK_LOG2, truncated.
- R5: The configuration register at offset 0x010 takes masked writes, except bit 1 (legacy routing), which always reads zero. Bit 0 is the global enable and drives enable_o.
- R6: count_o rises by one, modulo 2^32, in each cycle where tick_i is high, enable is set and no counter write takes place. In every other case it holds its value.
- R7: A legal write to the counter at offset 0x0F0 zero-extends the count to 64 bits, merges the write under the mask and keeps the low 32 bits. The write wins over a tick in the same cycle. rearm_o is high during a counter write when enable is set, and during a configuration write that raises enable from 0 to 1.
- R8: The status register at offset 0x020 holds one bit per timer, in bit i for timer i. A sts_set_i bit sets the matching status bit. A write clears exactly the bits that are set, written as one and under the mask, and sts_clr_o pulses those same bits in the write cycle. A set wins over a clear in the same cycle.
- R9: Offsets with no register read as zero, and writes to them change no state and forward nothing.
- R10: Timer i owns offsets 0x100 + 32*i: slot 0 at +0x00, slot 1 at +0x08 and slot 2 at +0x10. A legal access to one of these slots with i < NT pulses tmr_wr_o or tmr_rd_o, and carries tmr_idx_o = i, tmr_slot_o, and tmr_wdata_o / tmr_mask_o placed as in R3. A read returns tmr_rdata_i, with halves handled as in R3. Slot 3 and indices of NT or more are unmapped.
- R11: After reset the counter, configuration and status registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset into the block |
| size_i | input | 4 | Access size in bytes |
| wdata_i | input | 64 | Write data, low-aligned |
| rdata_o | output | 64 | Read data, valid in the cycle of the read |
| tick_i | input | 1 | Counter tick enable |
| sts_set_i | input | NT | Per-timer status set strobes |
| sts_clr_o | output | NT | Per-timer release strobes for cleared status bits |
| enable_o | output | 1 | Global enable |
| count_o | output | 32 | Main counter |
| rearm_o | output | 1 | Strobe that tells all timers to rearm |
| tmr_wr_o | output | 1 | Timer window write strobe |
| tmr_rd_o | output | 1 | Timer window read strobe |
| tmr_idx_o | output | IDX_W | Addressed timer |
| tmr_slot_o | output | 2 | Addressed register slot within the timer |
| tmr_wdata_o | output | 64 | Lane-placed write data for the timer |
| tmr_mask_o | output | 64 | Write mask for the timer |
| tmr_rdata_i | input | 64 | Read data from the addressed timer |

## Verification
The bench builds the block with NT = 3, the smallest legal timer count. With this setting, timer indices 3 to 7 and slot 3 fall in the swept range of offsets 0x000 to 0x1FF, so the unmapped part of the timer window gets checked next to the mapped part. Every offset in that range is read at sizes 1, 2, 4 and 8, and each result is compared against a model in the bench that applies the size, alignment and half-select rules. With a 32-bit counter at its default width, the counter is preset close to 2^32 so that ticking crosses the wrap. The identity word is checked for the NT-1 field of 2 and the tick period of 59604644 fs.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int OFS_CAP   = 'h000;
  localparam int OFS_CFG   = 'h010;
  localparam int OFS_STS   = 'h020;
  localparam int OFS_CNT   = 'h0F0;
  localparam int OFS_TMR   = 'h100;
  localparam int TMR_SHIFT = 5;   // 32-byte window per timer
  localparam logic [63:0] CFG_LEGACY = 64'h2;

  typedef enum logic [2:0] {
    RG_NONE, RG_CAP, RG_CFG, RG_STS, RG_CNT, RG_TMR
  } reg_sel_e;
endpackage

// File: rtl/evt_acc_decode.sv
module evt_acc_decode
  import evt_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int NT     = 8,
  parameter int IDX_W  = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        size_i,
  input  logic [63:0]       wdata_i,
  output logic              legal_o,
  output logic              upper_o,
  output logic              wide_o,
  output reg_sel_e          sel_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [1:0]        slot_o,
  output logic [63:0]       data_o,
  output logic [63:0]       mask_o
);
  localparam int TI_W = ADDR_W - TMR_SHIFT;

  logic [ADDR_W-1:0] base, toff;
  logic [TI_W-1:0]   tidx;

  assign wide_o  = (size_i == 4'd8);
  assign legal_o = (wide_o && addr_i[2:0] == 3'b000) ||
                   (size_i == 4'd4 && addr_i[1:0] == 2'b00);
  assign upper_o = !wide_o && addr_i[2];
  assign base    = {addr_i[ADDR_W-1:3], 3'b000};
  assign toff    = base - ADDR_W'(OFS_TMR);
  assign tidx    = toff[ADDR_W-1:TMR_SHIFT];
  assign idx_o   = IDX_W'(tidx);
  assign slot_o  = toff[4:3];

  always_comb begin
    sel_o = RG_NONE;
    if      (base == ADDR_W'(OFS_CAP)) sel_o = RG_CAP;
    else if (base == ADDR_W'(OFS_CFG)) sel_o = RG_CFG;
    else if (base == ADDR_W'(OFS_STS)) sel_o = RG_STS;
    else if (base == ADDR_W'(OFS_CNT)) sel_o = RG_CNT;
    else if (base >= ADDR_W'(OFS_TMR) && tidx < TI_W'(NT) && slot_o != 2'd3)
      sel_o = RG_TMR;
  end

  always_comb begin
    if (wide_o) begin
      data_o = wdata_i;
      mask_o = '1;
    end else if (upper_o) begin
      data_o = {wdata_i[31:0], 32'h0};
      mask_o = {32'hFFFF_FFFF, 32'h0};
    end else begin
      data_o = {32'h0, wdata_i[31:0]};
      mask_o = {32'h0, 32'hFFFF_FFFF};
    end
  end
endmodule

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic          wr_i,
  input  logic [63:0]   data_i,
  input  logic [63:0]   mask_i,
  output logic [CW-1:0] count_o
);
  logic [63:0] merged;

  assign merged = ({{(64-CW){1'b0}}, count_o} & ~mask_i) | (data_i & mask_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              count_o <= '0;
    else if (wr_i)            count_o <= merged[CW-1:0];
    else if (en_i && tick_i)  count_o <= count_o + 1'b1;
  end
endmodule

// File: rtl/evt_status.sv
module evt_status #(
  parameter int NT = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NT-1:0] set_i,
  input  logic          wr_i,
  input  logic [63:0]   data_i,
  input  logic [63:0]   mask_i,
  output logic [NT-1:0] sts_o,
  output logic [NT-1:0] clr_o
);
  assign clr_o = wr_i ? (sts_o & data_i[NT-1:0] & mask_i[NT-1:0]) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_o <= '0;
    else         sts_o <= (sts_o & ~clr_o) | set_i;
  end
endmodule

// File: rtl/evt_regif.sv
module evt_regif
  import evt_pkg::*;
#(
  parameter int          NT        = 8,
  parameter int          ADDR_W    = 11,
  parameter int          TICK_LOG2 = 24,
  parameter logic [15:0] VENDOR_ID = 16'h1D0F,
  localparam int         IDX_W     = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        size_i,
  input  logic [63:0]       wdata_i,
  output logic [63:0]       rdata_o,
  input  logic              tick_i,
  input  logic [NT-1:0]     sts_set_i,
  output logic [NT-1:0]     sts_clr_o,
  output logic              enable_o,
  output logic [31:0]       count_o,
  output logic              rearm_o,
  output logic              tmr_wr_o,
  output logic              tmr_rd_o,
  output logic [IDX_W-1:0]  tmr_idx_o,
  output logic [1:0]        tmr_slot_o,
  output logic [63:0]       tmr_wdata_o,
  output logic [63:0]       tmr_mask_o,
  input  logic [63:0]       tmr_rdata_i
);
  localparam longint unsigned FS_PER_S = 64'd1000000000000000;
  localparam logic [63:0]     TICK_FS  = FS_PER_S >> TICK_LOG2;
  localparam logic [63:0]     CAP_WORD = {TICK_FS[31:0], VENDOR_ID, 3'b000,
                                          5'(NT - 1), 8'd1};

  logic        legal, upper, wide;
  reg_sel_e    sel;
  logic [63:0] wdat, wmask, cfg_q, cfg_d, full;
  logic [NT-1:0] sts;
  logic        wr_hit, rd_hit;

  evt_acc_decode #(.ADDR_W(ADDR_W), .NT(NT), .IDX_W(IDX_W)) u_dec (
    .addr_i (addr_i),  .size_i (size_i), .wdata_i(wdata_i),
    .legal_o(legal),   .upper_o(upper),  .wide_o (wide),
    .sel_o  (sel),     .idx_o  (tmr_idx_o), .slot_o(tmr_slot_o),
    .data_o (wdat),    .mask_o (wmask)
  );

  assign wr_hit = req_i && we_i && legal;
  assign rd_hit = req_i && !we_i && legal;

  // configuration: masked merge, legacy routing forced off
  assign cfg_d = ((cfg_q & ~wmask) | (wdat & wmask)) & ~CFG_LEGACY;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cfg_q <= '0;
    else if (wr_hit && sel == RG_CFG) cfg_q <= cfg_d;
  end
  assign enable_o = cfg_q[0];

  evt_counter #(.CW(32)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(enable_o), .tick_i(tick_i),
    .wr_i(wr_hit && sel == RG_CNT), .data_i(wdat), .mask_i(wmask),
    .count_o(count_o)
  );

  evt_status #(.NT(NT)) u_sts (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(sts_set_i),
    .wr_i(wr_hit && sel == RG_STS), .data_i(wdat), .mask_i(wmask),
    .sts_o(sts), .clr_o(sts_clr_o)
  );

  assign rearm_o = wr_hit && ((sel == RG_CNT && enable_o) ||
                              (sel == RG_CFG && !enable_o && cfg_d[0]));

  assign tmr_wr_o    = wr_hit && sel == RG_TMR;
  assign tmr_rd_o    = rd_hit && sel == RG_TMR;
  assign tmr_wdata_o = wdat;
  assign tmr_mask_o  = wmask;

  always_comb begin
    unique case (sel)
      RG_CAP:  full = CAP_WORD;
      RG_CFG:  full = cfg_q;
      RG_STS:  full = {{(64-NT){1'b0}}, sts};
      RG_CNT:  full = {32'h0, count_o};
      RG_TMR:  full = tmr_rdata_i;
      default: full = '0;
    endcase
  end

  always_comb begin
    if (!rd_hit)    rdata_o = '0;
    else if (wide)  rdata_o = full;
    else if (upper) rdata_o = {32'h0, full[63:32]};
    else            rdata_o = {32'h0, full[31:0]};
  end
endmodule

// File: rtl/evt_regif_chk.sv
module evt_regif_chk #(
  parameter int NT = 8,
  localparam int IDX_W = (NT > 1) ? $clog2(NT) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic [3:0]       size_i,
  input logic [63:0]      rdata_o,
  input logic             tick_i,
  input logic             enable_o,
  input logic [31:0]      count_o,
  input logic [NT-1:0]    sts_clr_o,
  input logic             tmr_wr_o,
  input logic             tmr_rd_o,
  input logic [IDX_W-1:0] tmr_idx_o
);
  logic wr;
  assign wr = req_i && we_i;

  a_r1_bad_size_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && size_i != 4'd4 && size_i != 4'd8 |-> rdata_o == 64'h0);
  a_r3_half_read_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && size_i == 4'd4 |-> rdata_o[63:32] == 32'h0);
  a_r5_enable_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr |=> $stable(enable_o));
  a_r6_hold_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr && !(enable_o && tick_i) |=> $stable(count_o));
  a_r6_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr && enable_o && tick_i |=> count_o == $past(count_o) + 32'd1);
  a_r8_clr_only_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_clr_o != '0 |-> wr);
  a_r10_fwd_index_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_wr_o || tmr_rd_o |-> 32'(tmr_idx_o) < NT);
  a_r10_fwd_one_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tmr_wr_o, tmr_rd_o}));
endmodule

bind evt_regif evt_regif_chk #(.NT(NT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .size_i(size_i),
  .rdata_o(rdata_o), .tick_i(tick_i), .enable_o(enable_o), .count_o(count_o),
  .sts_clr_o(sts_clr_o), .tmr_wr_o(tmr_wr_o), .tmr_rd_o(tmr_rd_o),
  .tmr_idx_o(tmr_idx_o)
);

// File: tb/evt_regif_bench.sv
module evt_regif_bench;
  localparam int CLK_P  = 10;
  localparam int NT     = 3;
  localparam int AW     = 11;
  localparam int IW     = 2;
  localparam logic [63:0] TMR_PAT = 64'hA5C3_0F1E_7788_5AB4;
  localparam logic [15:0] VID     = 16'h1D0F;

  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0, tick = 0;
  logic [AW-1:0] addr = '0;
  logic [3:0]  size = 4'd8;
  logic [63:0] wdata = '0, rdata;
  logic [NT-1:0] sset = '0, sclr;
  logic en, rearm, twr, trd;
  logic [31:0] cnt;
  logic [IW-1:0] tidx;
  logic [1:0]  tslot;
  logic [63:0] twd, tmask;

  always #(CLK_P/2) clk = ~clk;

  evt_regif #(.NT(NT), .ADDR_W(AW), .VENDOR_ID(VID)) u_evt_regif (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .rdata_o(rdata), .tick_i(tick),
    .sts_set_i(sset), .sts_clr_o(sclr), .enable_o(en), .count_o(cnt),
    .rearm_o(rearm), .tmr_wr_o(twr), .tmr_rd_o(trd), .tmr_idx_o(tidx),
    .tmr_slot_o(tslot), .tmr_wdata_o(twd), .tmr_mask_o(tmask),
    .tmr_rdata_i(TMR_PAT)
  );

  int n_chk = 0, n_bad = 0;
  logic [63:0] cfg_m = '0, cap_m;
  logic [NT-1:0] sts_m = '0;
  logic [31:0] cnt_m = '0;
  logic [63:0] rd_c; logic [NT-1:0] clr_c; logic rearm_c, twr_c, trd_c;

  task automatic chk(input bit ok, input string r, input logic [63:0] act, exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  // caller is at a negedge; returns at the next negedge
  task automatic acc(input logic w, input logic [AW-1:0] a, input logic [3:0] s,
                     input logic [63:0] d);
    req = 1; we = w; addr = a; size = s; wdata = d;
    #1;
    rd_c = rdata; clr_c = sclr; rearm_c = rearm; twr_c = twr; trd_c = trd;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  function automatic logic [63:0] exp_rd(input int a, input int s);
    logic [63:0] f;
    int base, off;
    if (!(s == 4 || s == 8)) return 64'h0;
    if ((s == 8 && a % 8 != 0) || (s == 4 && a % 4 != 0)) return 64'h0;
    base = a - (a % 8);
    off  = base - 'h100;
    if      (base == 'h000) f = cap_m;
    else if (base == 'h010) f = cfg_m;
    else if (base == 'h020) f = 64'(sts_m);
    else if (base == 'h0F0) f = 64'(cnt_m);
    else if (off >= 0 && off / 32 < NT && (off % 32) / 8 != 3) f = TMR_PAT;
    else f = 64'h0;
    if (s == 4) f = (a % 8 == 4) ? {32'h0, f[63:32]} : {32'h0, f[31:0]};
    return f;
  endfunction

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] tp;
    tp = 64'd1000000000000000 / 64'd16777216;
    cap_m = {tp[31:0], VID, 3'b000, 5'(NT - 1), 8'd1};
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R11 reset state
    chk(cnt == 0 && en == 0, "R11 count/enable", {cnt, 31'h0, en}, 64'h0);
    acc(0, 11'h010, 8, 0); chk(rd_c == 0, "R11 cfg", rd_c, 0);
    acc(0, 11'h020, 8, 0); chk(rd_c == 0, "R11 sts", rd_c, 0);

    // R4 identity, read-only
    acc(1, 11'h000, 8, '1);
    acc(0, 11'h000, 8, 0); chk(rd_c == cap_m, "R4 cap", rd_c, cap_m);
    chk(rd_c[63:32] == 32'd59604644, "R4 tick fs", 64'(rd_c[63:32]), 64'd59604644);

    // R5 legacy bit forced low, enable rise rearms (R7)
    acc(1, 11'h010, 8, '1); cfg_m = ~64'h2;
    chk(rearm_c == 1, "R7 rearm on enable rise", 64'(rearm_c), 1);
    acc(0, 11'h010, 8, 0); chk(rd_c == cfg_m, "R5 legacy zero", rd_c, cfg_m);
    chk(en == 1, "R5 enable_o", 64'(en), 1);
    acc(1, 11'h010, 8, 64'h0); cfg_m = 0;
    chk(rearm_c == 0 && en == 0, "R7 no rearm on disable", 64'(rearm_c), 0);

    // R3 half access
    acc(1, 11'h014, 4, 64'hFFFF_FFFF_1234_5678); cfg_m = 64'h1234_5678_0000_0000;
    acc(0, 11'h010, 8, 0); chk(rd_c == cfg_m, "R3 upper merge", rd_c, cfg_m);
    acc(1, 11'h010, 4, 64'h9999_9999_0000_00F0); cfg_m[31:0] = 32'hF0;
    acc(0, 11'h010, 8, 0); chk(rd_c == cfg_m, "R3 lower merge", rd_c, cfg_m);
    acc(0, 11'h014, 4, 0); chk(rd_c == 64'h1234_5678, "R3 upper read", rd_c, 64'h1234_5678);

    // R1 / R2 ignored writes
    acc(1, 11'h010, 2, '1);
    acc(1, 11'h014, 8, '1);
    acc(1, 11'h012, 4, '1);
    acc(0, 11'h010, 8, 0); chk(rd_c == cfg_m, "R1 R2 cfg untouched", rd_c, cfg_m);
    acc(1, 11'h0F0, 1, '1);
    chk(cnt == 0, "R1 counter untouched", 64'(cnt), 0);

    // R9 unmapped writes
    acc(1, 11'h018, 8, '1); acc(1, 11'h0E8, 8, '1);
    acc(1, 11'h178, 8, '1);
    chk(twr_c == 0, "R9 slot3 not forwarded", 64'(twr_c), 0);
    acc(1, 11'h160, 8, '1);
    chk(twr_c == 0, "R9 index NT not forwarded", 64'(twr_c), 0);
    acc(0, 11'h010, 8, 0); chk(rd_c == cfg_m, "R9 cfg untouched", rd_c, cfg_m);

    // R10 forwarding
    req = 1; we = 1; addr = 11'h14C; size = 4; wdata = 64'h0000_0000_CAFE_F00D; #1;
    chk(twr == 1 && tidx == 2 && tslot == 1, "R10 idx/slot", {tidx, tslot, twr}, {2'd2, 2'd1, 1'b1});
    chk(twd == 64'hCAFE_F00D_0000_0000 && tmask == 64'hFFFF_FFFF_0000_0000,
        "R10 lane data", twd, 64'hCAFE_F00D_0000_0000);
    @(negedge clk); req = 0; we = 0;
    acc(0, 11'h130, 8, 0);
    chk(trd_c == 1 && rd_c == TMR_PAT, "R10 read", rd_c, TMR_PAT);

    // R7 counter preset near wrap, R6 ticking
    acc(1, 11'h0F0, 8, 64'h1_FFFF_FFF0); cnt_m = 32'hFFFF_FFF0;
    chk(rearm_c == 0, "R7 no rearm while off", 64'(rearm_c), 0);
    chk(cnt == cnt_m, "R7 zero-extend merge", 64'(cnt), 64'(cnt_m));
    acc(1, 11'h010, 4, 64'h1); cfg_m[31:0] = 32'h1;
    for (int i = 0; i < 40; i++) begin
      tick = (i % 3 != 0);
      if (tick) cnt_m++;
      @(negedge clk);
    end
    tick = 0;
    chk(cnt == cnt_m, "R6 tick wrap", 64'(cnt), 64'(cnt_m));
    tick = 1;
    acc(1, 11'h0F0, 4, 64'h100); cnt_m = 32'h100;
    tick = 0;
    chk(rearm_c == 1, "R7 rearm on write", 64'(rearm_c), 1);
    chk(cnt == cnt_m, "R7 write beats tick", 64'(cnt), 64'(cnt_m));
    acc(1, 11'h0F4, 4, 64'hDEAD);
    chk(cnt == cnt_m, "R7 upper write keeps count", 64'(cnt), 64'(cnt_m));
    acc(1, 11'h010, 4, 64'h0); cfg_m[31:0] = 0;
    tick = 1; repeat (10) @(negedge clk); tick = 0;
    chk(cnt == cnt_m, "R6 hold when off", 64'(cnt), 64'(cnt_m));

    // R8 status
    sset = 3'b101; @(negedge clk); sset = 0; sts_m = 3'b101;
    acc(0, 11'h020, 8, 0); chk(rd_c == 64'h5, "R8 set", rd_c, 5);
    acc(1, 11'h020, 8, 64'h3);
    chk(clr_c == 3'b001, "R8 clear strobe", 64'(clr_c), 1); sts_m = 3'b100;
    acc(1, 11'h024, 4, 64'h7);
    chk(clr_c == 0, "R8 masked-off clear", 64'(clr_c), 0);
    sset = 3'b100;
    acc(1, 11'h020, 8, 64'h4);
    sset = 0;
    acc(0, 11'h020, 8, 0); chk(rd_c == 64'h4, "R8 set beats clear", rd_c, 4);

    // sweep: every offset, every size
    for (int a = 0; a < 'h200; a++) begin
      for (int k = 0; k < 4; k++) begin
        int s;
        logic [63:0] e;
        s = 1 << k;
        acc(0, AW'(a), 4'(s), 0);
        e = exp_rd(a, s);
        chk(rd_c == e, (s == 4 || s == 8) ? "R9 R10 R3 sweep" : "R1 sweep", rd_c, e);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule